// File: doc/BRIEF.md
# Interrupt Request Qualifier

This block decides whether either of two interrupt sources may raise the CPU's interrupt exception. One source is a 32-bit interrupt controller. The other is a 16-bit DMA controller. Each cycle the block looks at the processor status word and at each source's status and mask words. If at least one source is both pending and allowed, it raises a registered request. The request carries a code word that shows which sources caused it.

A raised request stays up, with its code unchanged, until the exception unit acknowledges it. Once acknowledged, the block waits for a fixed hold-off of a few cycles before it may raise a new request. This lets the handler clear the source before the block looks at it again. If both sources are pending when a request is raised, they are merged into one request.

Top module: `irq_qualifier`

## Requirements
- R1: While reset is asserted, and on the first cycle after its release, `irq_req_o` is 0 and `irq_code_o` is all zeros.
- R2: No request is raised unless all four status conditions hold: status bit 0 (global interrupt enable) is 1, status bit 16 (extended enable) is 1, status bit 1 (exception level) is 0, and status bit 2 (error level) is 0.
- R3: The controller source qualifies when status bit 10 is 1 and the bitwise AND of `ctrl_stat_i` and `ctrl_mask_i` is nonzero. It is reported as bit 10 of the code.
- R4: The DMA source qualifies when status bit 11 is 1 and either the AND of `dma_stat_i` and `dma_ctl_i` is nonzero or bit 15 of `dma_ctl_i` is 1 (forced pending). It is reported as bit 11 of the code.
- R5: When both sources qualify together, one request is raised with code bits 10 and 11 both set. All other code bits are always 0, and the code is all zeros whenever no request is held.
- R6: When the block is idle and not in hold-off, a request appears on the rising edge that samples qualifying inputs.
- R7: While a request is held and not acknowledged, `irq_req_o` and `irq_code_o` stay unchanged, whatever the inputs do.
- R8: An acknowledge received while no request is held has no effect.
- R9: On the edge that samples `irq_ack_i` high with a request held, the request and code clear. No new request can be raised on the next RECHECK-1 edges. With a source still qualifying, the request returns on the RECHECK-th edge after the acknowledge (the 4th edge by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| status_i | input | 32 | Processor status word |
| ctrl_stat_i | input | CTRL_W (32) | Interrupt controller status |
| ctrl_mask_i | input | CTRL_W (32) | Interrupt controller mask |
| dma_stat_i | input | DMA_W (16) | DMA controller status |
| dma_ctl_i | input | DMA_W (16) | DMA controller mask/control (bit 15 forces pending) |
| irq_ack_i | input | 1 | Exception unit accepts the held request |
| irq_req_o | output | 1 | Registered, held interrupt request |
| irq_code_o | output | 32 | Source code: bit 10 controller, bit 11 DMA |

## Verification
Every result is registered. A request, and its code, can be seen one rising edge after the inputs that qualify it. An acknowledge clears both on the edge that samples it. A new request may return only on the fourth edge after that acknowledge. For each cycle, the driver computes the expected request and code at the rising edge from a model written from the requirements and queues them. The monitor then compares them against the outputs at the following falling edge, so each check falls exactly on the cycle the result is due.

// File: rtl/irqq_pkg.sv
package irqq_pkg;
    localparam int unsigned STATUS_W      = 32;
    localparam int unsigned CODE_W        = 32;
    localparam int unsigned IE_BIT        = 0;
    localparam int unsigned EXL_BIT       = 1;
    localparam int unsigned ERL_BIT       = 2;
    localparam int unsigned CTRL_SRC_BIT  = 10;
    localparam int unsigned DMA_SRC_BIT   = 11;
    localparam int unsigned DMA_FORCE_BIT = 15;
    localparam int unsigned EIE_BIT       = 16;

    typedef struct packed {
        logic ctrl;
        logic dma;
    } src_vec_t;
endpackage

// File: rtl/irqq_status_gate.sv
module irqq_status_gate
    import irqq_pkg::*;
(
    input  logic [STATUS_W-1:0] status_i,
    output logic                global_ok_o,
    output src_vec_t            master_en_o
);
    logic [STATUS_W-1:0] unused_status;

    always_comb begin
        global_ok_o = status_i[IE_BIT] && status_i[EIE_BIT]
                      && !status_i[EXL_BIT] && !status_i[ERL_BIT];
        master_en_o.ctrl = status_i[CTRL_SRC_BIT];
        master_en_o.dma  = status_i[DMA_SRC_BIT];
    end

    assign unused_status = status_i;
endmodule

// File: rtl/irqq_pend_detect.sv
module irqq_pend_detect #(
    parameter int unsigned W         = 32,
    parameter bit          FORCE_EN  = 1'b0,
    parameter int unsigned FORCE_BIT = 0
) (
    input  logic [W-1:0] stat_i,
    input  logic [W-1:0] mask_i,
    output logic         pending_o
);
    logic hit;

    assign hit = |(stat_i & mask_i);

    generate
        if (FORCE_EN) begin : g_force
            assign pending_o = hit || mask_i[FORCE_BIT];
        end else begin : g_plain
            assign pending_o = hit;
        end
    endgenerate
endmodule

// File: rtl/irqq_holdoff.sv
module irqq_holdoff #(
    parameter int unsigned RECHECK = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic idle_o
);
    localparam int unsigned CW = $clog2(RECHECK + 1);
    localparam logic [CW-1:0] LOAD_VAL = CW'(RECHECK - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = LOAD_VAL;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign idle_o = (cnt_q == '0);
endmodule

// File: rtl/irq_qualifier.sv
module irq_qualifier
    import irqq_pkg::*;
#(
    parameter int unsigned CTRL_W  = 32,
    parameter int unsigned DMA_W   = 16,
    parameter int unsigned RECHECK = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [STATUS_W-1:0] status_i,
    input  logic [CTRL_W-1:0]   ctrl_stat_i,
    input  logic [CTRL_W-1:0]   ctrl_mask_i,
    input  logic [DMA_W-1:0]    dma_stat_i,
    input  logic [DMA_W-1:0]    dma_ctl_i,
    input  logic                irq_ack_i,
    output logic                irq_req_o,
    output logic [CODE_W-1:0]   irq_code_o
);
    typedef struct packed {
        logic              req;
        logic [CODE_W-1:0] code;
    } state_t;

    state_t   st_d, st_q;
    logic     global_ok;
    src_vec_t master_en;
    src_vec_t pending;
    src_vec_t qualified;
    logic     hold_load;
    logic     hold_idle;

    irqq_status_gate u_gate (
        .status_i    (status_i),
        .global_ok_o (global_ok),
        .master_en_o (master_en)
    );

    irqq_pend_detect #(
        .W         (CTRL_W),
        .FORCE_EN  (1'b0),
        .FORCE_BIT (0)
    ) u_ctrl_pend (
        .stat_i    (ctrl_stat_i),
        .mask_i    (ctrl_mask_i),
        .pending_o (pending.ctrl)
    );

    irqq_pend_detect #(
        .W         (DMA_W),
        .FORCE_EN  (1'b1),
        .FORCE_BIT (DMA_FORCE_BIT)
    ) u_dma_pend (
        .stat_i    (dma_stat_i),
        .mask_i    (dma_ctl_i),
        .pending_o (pending.dma)
    );

    irqq_holdoff #(
        .RECHECK (RECHECK)
    ) u_holdoff (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (hold_load),
        .idle_o (hold_idle)
    );

    always_comb begin
        qualified.ctrl = global_ok && master_en.ctrl && pending.ctrl;
        qualified.dma  = global_ok && master_en.dma  && pending.dma;
    end

    always_comb begin
        st_d      = st_q;
        hold_load = 1'b0;
        if (st_q.req) begin
            if (irq_ack_i) begin
                st_d.req  = 1'b0;
                st_d.code = '0;
                hold_load = 1'b1;
            end
        end else if (hold_idle && (qualified.ctrl || qualified.dma)) begin
            st_d.req                = 1'b1;
            st_d.code               = '0;
            st_d.code[CTRL_SRC_BIT] = qualified.ctrl;
            st_d.code[DMA_SRC_BIT]  = qualified.dma;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_req_o  = st_q.req;
    assign irq_code_o = st_q.code;
endmodule

// File: rtl/irq_qualifier_chk.sv
module irq_qualifier_chk
    import irqq_pkg::*;
#(
    parameter int unsigned CTRL_W  = 32,
    parameter int unsigned DMA_W   = 16,
    parameter int unsigned RECHECK = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic [STATUS_W-1:0] status_i,
    input logic [CTRL_W-1:0]   ctrl_stat_i,
    input logic [CTRL_W-1:0]   ctrl_mask_i,
    input logic [DMA_W-1:0]    dma_stat_i,
    input logic [DMA_W-1:0]    dma_ctl_i,
    input logic                irq_ack_i,
    input logic                irq_req_o,
    input logic [CODE_W-1:0]   irq_code_o
);
    localparam int unsigned GW = $clog2(RECHECK + 1);
    localparam logic [CODE_W-1:0] SRC_BITS =
        (CODE_W'(1) << CTRL_SRC_BIT) | (CODE_W'(1) << DMA_SRC_BIT);

    logic [GW-1:0] since_ack_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_ack_q <= GW'(RECHECK);
        end else if (irq_req_o && irq_ack_i) begin
            since_ack_q <= '0;
        end else if (since_ack_q < GW'(RECHECK)) begin
            since_ack_q <= since_ack_q + 1'b1;
        end
    end

    a_r2_status_gate: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req_o) |-> $past(status_i[IE_BIT] && status_i[EIE_BIT]
                                   && !status_i[EXL_BIT] && !status_i[ERL_BIT]));

    a_r3_ctrl_cause: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq_req_o) && irq_code_o[CTRL_SRC_BIT])
            |-> $past(status_i[CTRL_SRC_BIT] && (|(ctrl_stat_i & ctrl_mask_i))));

    a_r4_dma_cause: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq_req_o) && irq_code_o[DMA_SRC_BIT])
            |-> $past(status_i[DMA_SRC_BIT]
                      && ((|(dma_stat_i & dma_ctl_i)) || dma_ctl_i[DMA_FORCE_BIT])));

    a_r5_code_shape: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o |-> ((irq_code_o != '0) && ((irq_code_o & ~SRC_BITS) == '0)));

    a_r5_code_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req_o |-> (irq_code_o == '0));

    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req_o && !irq_ack_i) |=> (irq_req_o && $stable(irq_code_o)));

    a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req_o && irq_ack_i) |=> !irq_req_o);

    a_r9_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req_o) |-> (since_ack_q >= GW'(RECHECK)));
endmodule

bind irq_qualifier irq_qualifier_chk #(
    .CTRL_W  (CTRL_W),
    .DMA_W   (DMA_W),
    .RECHECK (RECHECK)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .status_i    (status_i),
    .ctrl_stat_i (ctrl_stat_i),
    .ctrl_mask_i (ctrl_mask_i),
    .dma_stat_i  (dma_stat_i),
    .dma_ctl_i   (dma_ctl_i),
    .irq_ack_i   (irq_ack_i),
    .irq_req_o   (irq_req_o),
    .irq_code_o  (irq_code_o)
);

// File: tb/tb_irq_qualifier.sv
`timescale 1ns/1ps
module tb_irq_qualifier;
    localparam int RECHECK = 4;
    localparam logic [31:0] ST_OK = 32'h0001_0C01;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] status_i = '0;
    logic [31:0] ctrl_stat_i = '0;
    logic [31:0] ctrl_mask_i = '0;
    logic [15:0] dma_stat_i = '0;
    logic [15:0] dma_ctl_i = '0;
    logic        irq_ack_i = 1'b0;
    logic        irq_req_o;
    logic [31:0] irq_code_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [32:0] exp_q[$];
    string       tag_q[$];

    bit          m_req = 1'b0;
    logic [31:0] m_code = '0;
    int          m_wait = 0;

    always #2 clk = ~clk;

    irq_qualifier #(.CTRL_W(32), .DMA_W(16), .RECHECK(RECHECK)) dut (
        .clk(clk), .rst_n(rst_n), .status_i(status_i),
        .ctrl_stat_i(ctrl_stat_i), .ctrl_mask_i(ctrl_mask_i),
        .dma_stat_i(dma_stat_i), .dma_ctl_i(dma_ctl_i),
        .irq_ack_i(irq_ack_i), .irq_req_o(irq_req_o), .irq_code_o(irq_code_o)
    );

    task automatic check(input string tag, input logic [32:0] act, input logic [32:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual req=%0b code=%h expected req=%0b code=%h",
                     tag, act[32], act[31:0], exp[32], exp[31:0]);
        end
    endtask

    // Driver: applies one cycle of stimulus and queues the expected outputs.
    task automatic step(input logic [31:0] st, input logic [31:0] cs, input logic [31:0] cm,
                        input logic [15:0] ds, input logic [15:0] dc, input bit ack,
                        input string tag);
        bit gok, qc, qd;
        @(negedge clk);
        status_i = st; ctrl_stat_i = cs; ctrl_mask_i = cm;
        dma_stat_i = ds; dma_ctl_i = dc; irq_ack_i = ack;
        @(posedge clk);
        gok = st[0] && st[16] && !st[1] && !st[2];
        qc  = gok && st[10] && (|(cs & cm));
        qd  = gok && st[11] && ((|(ds & dc)) || dc[15]);
        if (m_req) begin
            if (ack) begin
                m_req = 1'b0; m_code = '0; m_wait = RECHECK - 1;
            end
        end else if (m_wait != 0) begin
            m_wait--;
        end else if (qc || qd) begin
            m_req = 1'b1;
            m_code = '0;
            m_code[10] = qc;
            m_code[11] = qd;
        end
        exp_q.push_back({m_req, m_code});
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step('0, '0, '0, '0, '0, 1'b0, tag);
    endtask

    // Monitor: compares results after each rising edge.
    always @(negedge clk) begin
        if (exp_q.size() != 0) begin
            logic [32:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, {irq_req_o, irq_code_o}, e);
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 during reset", {irq_req_o, irq_code_o}, 33'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {irq_req_o, irq_code_o}, 33'd0);

        // R2: each global condition blocks a pending controller source
        step(ST_OK & ~32'h1,     32'h1, 32'h1, '0, '0, 1'b0, "R2 IE clear");
        step(ST_OK & ~32'h10000, 32'h1, 32'h1, '0, '0, 1'b0, "R2 EIE clear");
        step(ST_OK | 32'h2,      32'h1, 32'h1, '0, '0, 1'b0, "R2 EXL set");
        step(ST_OK | 32'h4,      32'h1, 32'h1, '0, '0, 1'b0, "R2 ERL set");

        // R3: controller source
        step(ST_OK & ~32'h400, 32'h1, 32'h1, '0, '0, 1'b0, "R3 master off");
        step(ST_OK, 32'hF0, 32'h0F, '0, '0, 1'b0, "R3 disjoint mask");
        step(ST_OK, 32'h8000_0000, 32'h8000_0000, '0, '0, 1'b0, "R3 R6 raise");

        // R7: held while inputs change
        step(32'h0, '0, '0, 16'h1, 16'h1, 1'b0, "R7 hold inputs off");
        step(ST_OK | 32'h2, 32'hFF, 32'hFF, 16'h8000, 16'h8000, 1'b0, "R7 hold inputs changed");

        // R9: acknowledge, then a DMA source kept qualifying
        step(ST_OK, '0, '0, 16'h1, 16'h1, 1'b1, "R9 ack");
        for (int i = 0; i < 5; i++) step(ST_OK, '0, '0, 16'h1, 16'h1, 1'b0, "R9 holdoff then raise");
        step(ST_OK, '0, '0, '0, '0, 1'b1, "R9 ack again");
        idle(RECHECK, "R9 drain");

        // R4: DMA source
        step(ST_OK & ~32'h800, '0, '0, 16'h3, 16'h8003, 1'b0, "R4 master off");
        step(ST_OK, '0, '0, 16'h4, 16'h3, 1'b0, "R4 disjoint mask");
        step(ST_OK, '0, '0, 16'h0, 16'h8000, 1'b0, "R4 forced pending raise");
        step(ST_OK, '0, '0, '0, '0, 1'b1, "R4 ack");
        idle(RECHECK, "R4 drain");

        // R5: both sources at once
        step(ST_OK, 32'h3, 32'h2, 16'h4, 16'h4, 1'b0, "R5 both raise");
        step(ST_OK, '0, '0, '0, '0, 1'b1, "R5 ack");
        idle(RECHECK, "R5 drain");

        // R8: stray acknowledge, then a raise immediately after
        step('0, '0, '0, '0, '0, 1'b1, "R8 stray ack");
        step(ST_OK, 32'h10, 32'h10, '0, '0, 1'b1, "R8 raise with ack high");
        step(ST_OK, 32'h10, 32'h10, '0, '0, 1'b0, "R8 held");
        step(ST_OK, '0, '0, '0, '0, 1'b1, "R8 ack");
        idle(RECHECK + 1, "R8 drain");

        @(negedge clk);
        @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule